// File: doc/BRIEF.md
# Shadow-Loaded Four-Channel PWM Generator

This block produces a pulse-width-modulated waveform from a free-running time base and steers it onto up to four output pins, labelled A through D (`pwm_out[0]` is A, `pwm_out[3]` is D). The time base is an 8-bit period timer with a 2-bit sub-count below it, which gives a 10-bit position inside each period. A prescaler slows the whole time base down by 1, 4 or 16 input clocks per step. The primary waveform goes active at each period boundary and clears when the 10-bit position reaches the duty value. A steering stage places that waveform on the pins according to the selected output mode: single output, half-bridge with complementary outputs and a dead band, or full-bridge in either direction. Per-pair polarity inversion is applied last.

Software writes the settings through a simple byte-wide write port. Period, duty, mode, polarity and prescaler go into holding copies. They reach the running logic only when the timer wraps, so a waveform in progress is never cut short or stretched. The dead-band delay is the one exception: it is picked up at the duty boundary or at the period boundary, whichever comes first. While the enable bit is clear, the counters rest at zero and every setting passes straight through. Once enabled, the pins stay inactive until the first wrap.

Register addresses on `wr_addr`: 0 is the period (8 bits). 1 is the upper eight duty bits (duty[9:2]). 2 is the lower two duty bits in data[1:0]. 3 is control: bit 0 enable, bits 2:1 mode (0 single, 1 full-bridge forward, 2 half-bridge, 3 full-bridge reverse), bit 3 inverts A and C, bit 4 inverts B and D, and bits 6:5 select the prescale (0 gives 1, 1 gives 4, 2 or 3 give 16). 4 is the dead-band delay in data[6:0], counted in input clocks.

Top module: `pwmq_top`

## Requirements
- R1: While reset is asserted and after its release with enable clear, all four pins are 0 (inactive, since polarity resets to active-high).
- R2: With enable set, one period lasts (period+1)×4×prescale input clocks, where the prescale code 0 gives 1, code 1 gives 4, and codes 2 and 3 give 16.
- R3: The primary waveform is active for duty×prescale clocks from each period boundary. A duty of 0 never goes active. A duty of at least (period+1)×4 stays active for the whole period.
- R4: Writes to period, duty, mode, polarity or prescale made while running do not change the period in progress. They apply from the next period boundary.
- R5: After enable is set, all pins remain inactive for one full period; the first active level appears at the first wrap, (period+1)×4×prescale clocks after the enabling write.
- R6: In half-bridge mode (mode 2), A carries the waveform and B its complement. Each rising edge is delayed by the dead-band count in clocks, and A and B are never active together.
- R7: A new dead-band value written during the active phase of A takes effect at the duty boundary of that same period, so B's next rising edge already uses it.
- R8: In full-bridge forward (mode 1), A is held active, D carries the waveform, and B and C are inactive. In full-bridge reverse (mode 3), C is held active, B carries the waveform, and A and D are inactive.
- R9: Control bit 3 inverts the pin level of A and C, and control bit 4 inverts B and D.
- R10: In single mode (mode 0), only A carries the waveform; B, C and D stay inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 3 | Setting select (0 period, 1 duty high, 2 duty low, 3 control, 4 dead band) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | Pin levels, bit 0 is A through bit 3 is D, after polarity |

## Verification
The hardest case to reach is the choice between the two load points of the dead-band value. The difference only shows when the new value arrives after a period boundary and before the duty boundary of the same period, in half-bridge mode with both outputs in use. The bench synchronises on the observed rising edge of A and writes the new delay within the next two clocks. It then counts B's active clocks in that same period, which differ by three clocks between a duty-boundary load and a period-only load. A similar edge-synchronised write during A's active phase shows that duty and polarity changes wait for the wrap.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_FWD    = 2'd1,
      MODE_HALF   = 2'd2,
      MODE_REV    = 2'd3
   } pwmq_mode_e;

   localparam logic [2:0] ADDR_PERIOD  = 3'd0;
   localparam logic [2:0] ADDR_DUTY_HI = 3'd1;
   localparam logic [2:0] ADDR_DUTY_LO = 3'd2;
   localparam logic [2:0] ADDR_CTRL    = 3'd3;
   localparam logic [2:0] ADDR_DBAND   = 3'd4;

   localparam int PRE_W = 4;

   // last prescaler count value for a prescale code (1, 4 or 16 clocks per step)
   function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] code);
      case (code)
         2'd0:    pre_last = PRE_W'(0);
         2'd1:    pre_last = PRE_W'(3);
         default: pre_last = PRE_W'(15);
      endcase
   endfunction

endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
   import pwmq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TMR_W  = 8,
   parameter int DB_W   = 7,
   localparam int DUTY_W = TMR_W + 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wrap_i,
   input  logic              duty_hit_i,
   output logic              en_o,
   output logic [TMR_W-1:0]  period_act,
   output logic [DUTY_W-1:0] duty_act,
   output logic [DUTY_W-1:0] duty_nx_o,
   output pwmq_mode_e        mode_act,
   output logic              inv_ac_act,
   output logic              inv_bd_act,
   output logic [1:0]        pre_act,
   output logic [DB_W-1:0]   db_act
);

   logic [TMR_W-1:0]  per_sh, per_nx;
   logic [DUTY_W-1:0] duty_sh, duty_nx;
   logic              en_sh, en_nx;
   pwmq_mode_e        mode_sh, mode_nx;
   logic              iac_sh, iac_nx, ibd_sh, ibd_nx;
   logic [1:0]        pre_sh, pre_nx;
   logic [DB_W-1:0]   db_sh, db_nx;
   logic              load_all, load_db;
   logic              unused_bits;

   assign unused_bits = ^wr_data;

   always_comb begin
      per_nx  = per_sh;
      duty_nx = duty_sh;
      en_nx   = en_sh;
      mode_nx = mode_sh;
      iac_nx  = iac_sh;
      ibd_nx  = ibd_sh;
      pre_nx  = pre_sh;
      db_nx   = db_sh;
      if (wr_en) begin
         case (wr_addr)
            ADDR_PERIOD:  per_nx = wr_data[TMR_W-1:0];
            ADDR_DUTY_HI: duty_nx[DUTY_W-1:2] = wr_data[TMR_W-1:0];
            ADDR_DUTY_LO: duty_nx[1:0] = wr_data[1:0];
            ADDR_CTRL: begin
               en_nx   = wr_data[0];
               mode_nx = pwmq_mode_e'(wr_data[2:1]);
               iac_nx  = wr_data[3];
               ibd_nx  = wr_data[4];
               pre_nx  = wr_data[6:5];
            end
            ADDR_DBAND:   db_nx = wr_data[DB_W-1:0];
            default: ;
         endcase
      end
   end

   // settings flow straight through while stopped; otherwise only at the wrap
   assign load_all  = !en_sh || wrap_i;
   assign load_db   = load_all || duty_hit_i;
   assign en_o      = en_sh;
   assign duty_nx_o = duty_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh  <= '0;
         duty_sh <= '0;
         en_sh   <= 1'b0;
         mode_sh <= MODE_SINGLE;
         iac_sh  <= 1'b0;
         ibd_sh  <= 1'b0;
         pre_sh  <= '0;
         db_sh   <= '0;
      end else begin
         per_sh  <= per_nx;
         duty_sh <= duty_nx;
         en_sh   <= en_nx;
         mode_sh <= mode_nx;
         iac_sh  <= iac_nx;
         ibd_sh  <= ibd_nx;
         pre_sh  <= pre_nx;
         db_sh   <= db_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_act <= '0;
         duty_act   <= '0;
         mode_act   <= MODE_SINGLE;
         inv_ac_act <= 1'b0;
         inv_bd_act <= 1'b0;
         pre_act    <= '0;
      end else if (load_all) begin
         period_act <= per_nx;
         duty_act   <= duty_nx;
         mode_act   <= mode_nx;
         inv_ac_act <= iac_nx;
         inv_bd_act <= ibd_nx;
         pre_act    <= pre_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       db_act <= '0;
      else if (load_db) db_act <= db_nx;
   end

   // R4: running settings hold between period boundaries
   a_r4_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
      (en_sh && !wrap_i) |=> ($stable(duty_act) && $stable(period_act) && $stable(mode_act)));

   // R7: dead band changes only at a duty or period boundary
   a_r7_db_load_points: assert property (@(posedge clk) disable iff (!rst_n)
      (en_sh && !wrap_i && !duty_hit_i) |=> $stable(db_act));

endmodule

// File: rtl/pwmq_timebase.sv
module pwmq_timebase
   import pwmq_pkg::*;
#(
   parameter int TMR_W = 8,
   localparam int SUB_W  = 2,
   localparam int DUTY_W = TMR_W + SUB_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [TMR_W-1:0]  period_i,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic [DUTY_W-1:0] duty_next_i,
   input  logic [1:0]        pre_i,
   output logic              wrap_o,
   output logic              duty_hit_o,
   output logic              started_o,
   output logic              wave_o
);

   logic [PRE_W-1:0]  pre_cnt;
   logic [DUTY_W-1:0] pos, pos_inc;
   logic [TMR_W-1:0]  tmr;
   logic [SUB_W-1:0]  sub;
   logic              tick, at_end;

   assign tmr        = pos[DUTY_W-1:SUB_W];
   assign sub        = pos[SUB_W-1:0];
   assign pos_inc    = pos + DUTY_W'(1);
   assign tick       = en_i && (pre_cnt == pre_last(pre_i));
   assign at_end     = (tmr == period_i) && (&sub);
   assign wrap_o     = tick && at_end;
   assign duty_hit_o = tick && !at_end && (pos_inc == duty_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_cnt <= '0;
      else if (!en_i || tick)    pre_cnt <= '0;
      else                       pre_cnt <= pre_cnt + PRE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos       <= '0;
         started_o <= 1'b0;
         wave_o    <= 1'b0;
      end else if (!en_i) begin
         pos       <= '0;
         started_o <= 1'b0;
         wave_o    <= 1'b0;
      end else if (wrap_o) begin
         pos       <= '0;
         started_o <= 1'b1;
         wave_o    <= (duty_next_i != '0);
      end else if (tick) begin
         pos <= pos_inc;
         if (duty_hit_o) wave_o <= 1'b0;
      end
   end

   // R2: the wrap returns the time base to zero
   a_r2_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (pos == '0));

   // R2: the timer never runs past the active period
   a_r2_tmr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      started_o |-> (tmr <= period_i));

   // R3: a zero duty leaves the waveform inactive after the wrap
   a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_o && duty_next_i == '0) |=> !wave_o);

   // R5: no waveform before the first wrap
   a_r5_no_early_wave: assert property (@(posedge clk) disable iff (!rst_n)
      !started_o |-> !wave_o);

endmodule

// File: rtl/pwmq_deadband.sv
module pwmq_deadband #(
   parameter int NUM_CH = 4,
   parameter int DB_W   = 7
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] raw_i,
   input  logic [DB_W-1:0]   db_i,
   output logic [NUM_CH-1:0] out_o
);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DB_W-1:0] held;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              held <= '0;
         else if (!raw_i[ch])     held <= '0;
         else if (held < db_i)    held <= held + DB_W'(1);
      end

      assign out_o[ch] = raw_i[ch] && (held >= db_i);

      // R6: a delayed rising edge follows a raw level that was already high
      a_r6_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
         (db_i != '0 && $rose(out_o[ch])) |-> $past(raw_i[ch]));
   end

endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
   import pwmq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int TMR_W   = 8,
   parameter int DB_W    = 7,
   parameter int NUM_OUT = 4,
   localparam int DUTY_W = TMR_W + 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   wr_addr,
   input  logic [7:0]   wr_data,
   output logic [3:0]   pwm_out
);

   if (NUM_OUT != 4 || DATA_W != 8 || TMR_W > DATA_W || DB_W > DATA_W || TMR_W < 2) begin : g_bad_cfg
      $error("pwmq_top: unsupported parameter combination");
   end

   logic              en, wrap, duty_hit, started, wave;
   logic [TMR_W-1:0]  period_act;
   logic [DUTY_W-1:0] duty_act, duty_nx;
   pwmq_mode_e        mode_act;
   logic              inv_ac, inv_bd;
   logic [1:0]        pre_act;
   logic [DB_W-1:0]   db_act, db_eff;
   logic [NUM_OUT-1:0] raw, act, inv;

   pwmq_regs #(.DATA_W(DATA_W), .TMR_W(TMR_W), .DB_W(DB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wrap_i(wrap), .duty_hit_i(duty_hit), .en_o(en),
      .period_act(period_act), .duty_act(duty_act), .duty_nx_o(duty_nx),
      .mode_act(mode_act), .inv_ac_act(inv_ac), .inv_bd_act(inv_bd),
      .pre_act(pre_act), .db_act(db_act)
   );

   pwmq_timebase #(.TMR_W(TMR_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .en_i(en), .period_i(period_act),
      .duty_i(duty_act), .duty_next_i(duty_nx), .pre_i(pre_act),
      .wrap_o(wrap), .duty_hit_o(duty_hit), .started_o(started), .wave_o(wave)
   );

   // output steering per mode (bit 0 = A ... bit 3 = D)
   always_comb begin
      raw = '0;
      case (mode_act)
         MODE_SINGLE: raw[0] = wave;
         MODE_HALF: begin
            raw[0] = wave;
            raw[1] = started && !wave;
         end
         MODE_FWD: begin
            raw[0] = started;
            raw[3] = wave;
         end
         MODE_REV: begin
            raw[2] = started;
            raw[1] = wave;
         end
         default: raw = '0;
      endcase
   end

   assign db_eff = (mode_act == MODE_HALF) ? db_act : '0;

   pwmq_deadband #(.NUM_CH(NUM_OUT), .DB_W(DB_W)) u_db (
      .clk(clk), .rst_n(rst_n), .raw_i(raw), .db_i(db_eff), .out_o(act)
   );

   assign inv     = {inv_bd, inv_ac, inv_bd, inv_ac};
   assign pwm_out = act ^ inv;

   // R6: complementary pair never active together
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == MODE_HALF) |-> !(act[0] && act[1]));

   // R5: nothing active before the first wrap
   a_r5_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (act == '0));

   // R10: single mode drives only A
   a_r10_single_only_a: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == MODE_SINGLE) |-> (act[3:1] == '0));

   // R8: in a full-bridge mode exactly one steady leg is active once running
   a_r8_bridge_leg: assert property (@(posedge clk) disable iff (!rst_n)
      (started && (mode_act == MODE_FWD || mode_act == MODE_REV)) |-> $onehot0(act & 4'b0101) && ((act & 4'b0101) != '0));

endmodule

// File: tb/pwmq_top_tb.sv
module pwmq_top_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] pwm_out;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit half_on = 1'b0;
   int ovl = 0;

   always #5 clk = ~clk;

   pwmq_top u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .pwm_out(pwm_out));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   always @(negedge clk) if (half_on && pwm_out[0] && pwm_out[1]) ovl = ovl + 1;

   // {period, duty, prescale code, expected period clocks, expected active clocks}
   localparam int NV = 5;
   localparam int VEC [NV][5] = '{
      '{9,  20, 0, 40,  20},
      '{4,  3,  1, 80,  12},
      '{2,  5,  2, 192, 80},
      '{0,  1,  0, 4,   1},
      '{15, 63, 0, 64,  63}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; the write is taken at the following rising edge
   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(input int ch, input bit lvl, output int hi, output int per);
      int lo;
      while (pwm_out[ch] == lvl) @(negedge clk);
      while (pwm_out[ch] != lvl) @(negedge clk);
      hi = 0; lo = 0;
      while (pwm_out[ch] == lvl) begin hi++; @(negedge clk); end
      while (pwm_out[ch] != lvl) begin lo++; @(negedge clk); end
      per = hi + lo;
   endtask

   task automatic setup(input int p, input int d, input int ctrl);
      wr(3, ctrl & 8'hFE);
      wr(0, p);
      wr(1, d >> 2);
      wr(2, d & 3);
      wr(3, ctrl);
   endtask

   initial begin
      int hi, per, c, c2;
      repeat (3) @(negedge clk);
      chk("R1 in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 after reset", int'(pwm_out), 0);

      // table walk, single mode
      for (int i = 0; i < NV; i++) begin
         setup(VEC[i][0], VEC[i][1], 1 | (VEC[i][2] << 5));
         c = 0;
         while (!pwm_out[0]) begin c++; @(negedge clk); end
         chk("R5 start delay", c, VEC[i][3]);
         measure(0, 1'b1, hi, per);
         chk("R2 period", per, VEC[i][3]);
         chk("R3 active time", hi, VEC[i][4]);
         c2 = 0;
         for (int k = 0; k < VEC[i][3]; k++) begin
            if (pwm_out[3:1] != 3'b000) c2++;
            @(negedge clk);
         end
         chk("R10 B/C/D idle", c2, 0);
      end

      // R3: zero duty
      setup(3, 0, 1);
      c = 0;
      for (int k = 0; k < 80; k++) begin if (pwm_out[0]) c++; @(negedge clk); end
      chk("R3 zero duty", c, 0);

      // R3: duty at full scale
      setup(3, 16, 1);
      repeat (17) @(negedge clk);
      c = 0;
      for (int k = 0; k < 64; k++) begin if (pwm_out[0]) c++; @(negedge clk); end
      chk("R3 full duty", c, 64);

      // R4: duty written during the active phase waits for the wrap
      setup(9, 20, 1);
      while (!pwm_out[0]) @(negedge clk);
      wr(2, 1);
      wr(1, 1);
      c = 2;
      while (pwm_out[0]) begin c++; @(negedge clk); end
      chk("R4 duty held", c, 20);
      measure(0, 1'b1, hi, per);
      chk("R4 new duty", hi, 5);

      // R4/R9: polarity written mid-period, applied at the wrap
      wr(3, 1 | 8);
      chk("R4 polarity held", int'(pwm_out[0]), 1);
      repeat (39) @(negedge clk);
      chk("R9 A inverted", int'(pwm_out[0]), 0);
      c = 0;
      while (!pwm_out[0]) begin c++; @(negedge clk); end
      chk("R9 inverted active time", c, 5);

      // R6: half-bridge with dead band 3
      wr(3, 0);
      wr(4, 3);
      half_on = 1'b1;
      setup(9, 20, 1 | (2 << 1));
      measure(0, 1'b1, hi, per);
      chk("R6 A delayed active time", hi, 17);
      chk("R6 period", per, 40);
      c = 0;
      for (int k = 0; k < 40; k++) begin if (pwm_out[1]) c++; @(negedge clk); end
      chk("R6 B delayed active time", c, 17);

      // R7: new dead band written before the duty boundary applies to B at once
      wr(4, 6);
      c = 0;
      for (int k = 0; k < 39; k++) begin if (pwm_out[1]) c++; @(negedge clk); end
      chk("R7 B uses new dead band", c, 14);
      c = 0;
      for (int k = 0; k < 40; k++) begin if (pwm_out[0]) c++; @(negedge clk); end
      chk("R7 A uses new dead band", c, 14);
      half_on = 1'b0;
      chk("R6 no overlap", ovl, 0);

      // R8: full-bridge forward then reverse
      setup(9, 20, 1 | (1 << 1));
      measure(3, 1'b1, hi, per);
      chk("R8 fwd D active time", hi, 20);
      c = 0; c2 = 0;
      for (int k = 0; k < 40; k++) begin
         if (pwm_out[0]) c++;
         if (pwm_out[1] || pwm_out[2]) c2++;
         @(negedge clk);
      end
      chk("R8 fwd A steady", c, 40);
      chk("R8 fwd B/C idle", c2, 0);
      wr(3, 1 | (3 << 1));
      measure(1, 1'b1, hi, per);
      chk("R8 rev B active time", hi, 20);
      c = 0; c2 = 0;
      for (int k = 0; k < 40; k++) begin
         if (pwm_out[2]) c++;
         if (pwm_out[0] || pwm_out[3]) c2++;
         @(negedge clk);
      end
      chk("R8 rev C steady", c, 40);
      chk("R8 rev A/D idle", c2, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule